// File: doc/BRIEF.md
# Capture/Compare Channel Event Flag

One channel of a 16-bit timer, reached through a byte-wide register port. In capture mode the channel watches an external pin, synchronises it, and on a selected edge copies the running counter into its 16-bit value register. In compare mode it raises an event whenever the running counter equals that value register. Each event sets a sticky event flag. The flag drives either an interrupt request or a DMA-service request, depending on a service-select input that comes from a shared timer control register outside this block.

Software clears the flag in one of two ways. In interrupt mode it reads the status byte while the flag is set and then writes a zero to the flag bit. Any event that lands between that read and that write cancels the clear, so no request is lost. In DMA mode the flag is cleared by any access to the low byte of the value register. A read of the high value byte freezes a copy of the low byte and holds off flag setting until the low byte is read. Events in that window are kept pending and set the flag when the low-byte read completes.

Top module: `capcmp_channel`

## Requirements
- R1: After reset the status byte, both value bytes, `irq_req` and `dma_req` all read as 0.
- R2: Address 0 is the status byte, address 1 the value high byte and address 2 the value low byte. The status byte holds, from bit 7 down: event flag, interrupt enable, a constant 0, mode (1 = compare, 0 = capture), edge select B, edge select A, toggle-on-overflow and max-duty. Bits 6 and 4..0 read back what was written.
- R3: In capture mode the edge select {B,A} works as follows: 00 captures nothing, 01 captures rising edges, 10 captures falling edges and 11 captures both. The pin passes through two synchroniser flops. A capture copies the counter into the value register and sets the flag.
- R4: In compare mode the flag sets in any cycle in which the counter equals the value register.
- R5: Outside DMA mode, a zero write to status bit 7 clears the flag only if an earlier status read saw the flag at 1. A zero write with no such read leaves the flag set.
- R6: An event after the arming read, or in the same cycle as the zero write, leaves the flag set after that write.
- R7: Writing 1 to status bit 7 never changes the flag.
- R8: In DMA mode (interrupt enable 1 and `svc_dma` 1), a read or a write of the low value byte clears the flag. A zero write to the status byte does not clear it.
- R9: `irq_req` is flag AND enable AND NOT `svc_dma`. `dma_req` is flag AND enable AND `svc_dma`.
- R10: After a read of the high value byte, events do not set the flag until the low byte is read. Events held in that window set the flag on the low-byte read.
- R11: A low-byte read that follows a high-byte read returns the low byte as it stood at the high-byte read, even if a capture happened in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cap_pin | input | 1 | Asynchronous capture input |
| cnt_value | input | 16 | Free-running counter value |
| svc_dma | input | 1 | Service select: 1 routes the flag to DMA |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA-service request |

## Verification
The risky collision is a new capture or compare event arriving in the very cycle of the zero write that would clear an armed flag. The bench provokes it by arming the interlock with a status read and then driving the counter equal to the compare value on the same edge as the clearing write. The event must win: `irq_req` has to stay high afterwards, and a later read-then-write pair has to clear the flag normally. A second collision, an event held back by a high-byte read and released by the low-byte read, is judged by the flag staying clear until that read and being set right after it.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    AD_STAT = 2'd0,
    AD_VHI  = 2'd1,
    AD_VLO  = 2'd2,
    AD_RSV  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic ie;
    logic ms;
    logic elsb;
    logic elsa;
    logic tov;
    logic maxd;
  } ctrl_t;

  // Edge selection {B,A}: bit A enables rising, bit B enables falling.
  function automatic logic edge_hit(input logic [1:0] sel, input logic rise,
                                    input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic flag, input ctrl_t c);
    return {flag, c.ie, 1'b0, c.ms, c.elsb, c.elsa, c.tov, c.maxd};
  endfunction

  function automatic ctrl_t ctrl_from_byte(input logic [BYTE_W-1:0] b);
    ctrl_t c;
    c.ie   = b[6];
    c.ms   = b[4];
    c.elsb = b[3];
    c.elsa = b[2];
    c.tov  = b[1];
    c.maxd = b[0];
    return c;
  endfunction

endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // chain[SYNC_STAGES-1] is the synchronised level, chain[SYNC_STAGES] its delayed copy
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], pin};
  end

  assign rise =  chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign fall = ~chain[SYNC_STAGES-1] &  chain[SYNC_STAGES];
endmodule

// File: rtl/capcmp_valreg.sv
module capcmp_valreg #(
  parameter int BYTE_W = 8,
  localparam int VAL_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_load,
  input  logic [VAL_W-1:0]  cnt,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              hi_rd,
  input  logic              lo_rd,
  output logic [VAL_W-1:0]  val,
  output logic [BYTE_W-1:0] lo_view,
  output logic              blk
);
  logic [BYTE_W-1:0] lo_snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else if (cap_load) begin
      val <= cnt;
    end else begin
      if (wr_hi) val[VAL_W-1:BYTE_W] <= wdata;
      if (wr_lo) val[BYTE_W-1:0]     <= wdata;
    end
  end

  // High-byte read freezes the low byte and blocks the flag until the low byte is read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk     <= 1'b0;
      lo_snap <= '0;
    end else if (hi_rd) begin
      blk     <= 1'b1;
      lo_snap <= val[BYTE_W-1:0];
    end else if (lo_rd) begin
      blk     <= 1'b0;
    end
  end

  assign lo_view = blk ? lo_snap : val[BYTE_W-1:0];
endmodule

// File: rtl/capcmp_flag.sv
module capcmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic blk,
  input  logic lo_rd,
  input  logic lo_acc,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic wbit7,
  input  logic dma_mode,
  output logic flag,
  output logic armed,
  output logic pend,
  output logic flag_set,
  output logic clr_cpu,
  output logic clr_dma
);
  logic release_now;

  assign release_now = blk & lo_rd & (pend | evt);
  assign flag_set    = (evt & ~blk) | release_now;
  assign clr_cpu     = stat_wr & ~wbit7 & armed & ~dma_mode;
  assign clr_dma     = lo_acc & dma_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (flag_set)          flag <= 1'b1;
    else if (clr_cpu | clr_dma) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pend <= 1'b0;
    else if (blk & lo_rd)   pend <= 1'b0;
    else if (blk & evt)     pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed <= 1'b0;
    else if (evt | flag_set)   armed <= 1'b0;
    else if (stat_rd & flag)   armed <= 1'b1;
    else if (stat_wr)          armed <= 1'b0;
  end
endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
  import capcmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int VAL_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cap_pin,
  input  logic [VAL_W-1:0]  cnt_value,
  input  logic              svc_dma,
  output logic              irq_req,
  output logic              dma_req
);
  ctrl_t ctrl;
  logic stat_rd, stat_wr, hi_rd, lo_rd, hi_wr, lo_wr, lo_acc, wbit7;
  logic rise, fall, cap_evt, cmp_evt, evt, dma_mode;
  logic flag, armed, pend, blk, flag_set, clr_cpu, clr_dma;
  logic [VAL_W-1:0]  val;
  logic [BYTE_W-1:0] lo_view;

  assign stat_rd = bus_rd & (bus_addr == AD_STAT);
  assign stat_wr = bus_wr & (bus_addr == AD_STAT);
  assign hi_rd   = bus_rd & (bus_addr == AD_VHI);
  assign hi_wr   = bus_wr & (bus_addr == AD_VHI);
  assign lo_rd   = bus_rd & (bus_addr == AD_VLO);
  assign lo_wr   = bus_wr & (bus_addr == AD_VLO);
  assign lo_acc  = lo_rd | lo_wr;
  assign wbit7   = bus_wdata[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (stat_wr) ctrl <= ctrl_from_byte(bus_wdata);
  end

  capcmp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(rise), .fall(fall)
  );

  assign cap_evt  = ~ctrl.ms & edge_hit({ctrl.elsb, ctrl.elsa}, rise, fall);
  assign cmp_evt  =  ctrl.ms & (cnt_value == val);
  assign evt      = cap_evt | cmp_evt;
  assign dma_mode = ctrl.ie & svc_dma;

  capcmp_valreg #(.BYTE_W(BYTE_W)) u_val (
    .clk(clk), .rst_n(rst_n), .cap_load(cap_evt), .cnt(cnt_value),
    .wr_hi(hi_wr), .wr_lo(lo_wr), .wdata(bus_wdata),
    .hi_rd(hi_rd), .lo_rd(lo_rd), .val(val), .lo_view(lo_view), .blk(blk)
  );

  capcmp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt(evt), .blk(blk), .lo_rd(lo_rd),
    .lo_acc(lo_acc), .stat_rd(stat_rd), .stat_wr(stat_wr), .wbit7(wbit7),
    .dma_mode(dma_mode), .flag(flag), .armed(armed), .pend(pend),
    .flag_set(flag_set), .clr_cpu(clr_cpu), .clr_dma(clr_dma)
  );

  always_comb begin
    unique case (bus_addr)
      AD_STAT: bus_rdata = status_byte(flag, ctrl);
      AD_VHI:  bus_rdata = val[VAL_W-1:BYTE_W];
      AD_VLO:  bus_rdata = lo_view;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_req = flag & ctrl.ie & ~svc_dma;
  assign dma_req = flag & ctrl.ie &  svc_dma;
endmodule

// File: rtl/capcmp_channel_chk.sv
module capcmp_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic flag,
  input logic armed,
  input logic blk,
  input logic evt,
  input logic lo_rd,
  input logic stat_wr,
  input logic wbit7,
  input logic dma_mode,
  input logic irq_req,
  input logic dma_req
);
  a_r4_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !blk) |=> flag);

  a_r5_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed && !dma_mode) |=> flag);

  a_r6_event_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !armed);

  a_r7_one_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && stat_wr && wbit7) |=> flag);

  a_r9_requests_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req && dma_req));

  a_r10_blocked_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !lo_rd) |=> !$rose(flag));
endmodule

bind capcmp_channel capcmp_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag(flag), .armed(armed), .blk(blk), .evt(evt),
  .lo_rd(lo_rd), .stat_wr(stat_wr), .wbit7(wbit7), .dma_mode(dma_mode),
  .irq_req(irq_req), .dma_req(dma_req)
);

// File: tb/capcmp_channel_tb.sv
module capcmp_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDLE_CNT = 16'hF000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cap_pin = 1'b0;
  logic [15:0] cnt_value = IDLE_CNT;
  logic        svc_dma = 1'b0;
  logic        irq_req, dma_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capcmp_channel u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .cnt_value(cnt_value), .svc_dma(svc_dma),
    .irq_req(irq_req), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_val(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd1, h);
    rd(2'd2, l);
    v = {h, l};
  endtask

  task automatic set_pin(input logic lvl);
    @(negedge clk);
    cap_pin = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_pulse(input logic [15:0] v);
    @(negedge clk);
    cnt_value = v;
    @(negedge clk);
    cnt_value = IDLE_CNT;
    #1;
  endtask

  task automatic clear_flag(input logic [7:0] ctrl);
    logic [7:0] d;
    rd(2'd0, d);
    wr(2'd0, ctrl);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1 status after reset", d, 8'h00);
    rd(2'd1, d); chk("R1 value high after reset", d, 8'h00);
    rd(2'd2, d); chk("R1 value low after reset", d, 8'h00);
    chk("R1 irq after reset", irq_req, 0);
    chk("R1 dma after reset", dma_req, 0);
  endtask

  task automatic t_layout;
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R2 status readback, bit5 zero, R7 flag untouched", d, 8'h5F);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R2 status cleared", d, 8'h00);
  endtask

  task automatic t_capture;
    logic [7:0] d;
    logic [15:0] v;
    cnt_value = 16'h1234;
    wr(2'd0, 8'h04);
    set_pin(1'b1);
    rd(2'd0, d); chk("R3 rising edge sets flag", d, 8'h84);
    rd_val(v); chk("R3 counter captured", v, 16'h1234);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R5 read then zero write clears", d, 8'h04);
    set_pin(1'b0);
    rd(2'd0, d); chk("R3 falling edge ignored in rising mode", d, 8'h04);
    cnt_value = 16'h2222;
    wr(2'd0, 8'h08);
    set_pin(1'b1);
    rd(2'd0, d); chk("R3 rising ignored in falling mode", d, 8'h08);
    set_pin(1'b0);
    rd(2'd0, d); chk("R3 falling edge sets flag", d, 8'h88);
    rd_val(v); chk("R3 falling capture value", v, 16'h2222);
    wr(2'd0, 8'h00);
    cnt_value = 16'h3333;
    set_pin(1'b1);
    rd(2'd0, d); chk("R3 select 00 captures nothing", d, 8'h00);
    rd_val(v); chk("R3 select 00 keeps value", v, 16'h2222);
    cnt_value = 16'h0101;
    wr(2'd0, 8'h0C);
    set_pin(1'b0);
    rd(2'd0, d); chk("R3 both edges: falling", d, 8'h8C);
    wr(2'd0, 8'h0C);
    set_pin(1'b1);
    rd(2'd0, d); chk("R3 both edges: rising", d, 8'h8C);
    clear_flag(8'h00);
    cnt_value = IDLE_CNT;
  endtask

  task automatic t_compare;
    logic [7:0] d;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h50);
    wr(2'd0, 8'h10);
    rd(2'd0, d); chk("R4 no match no flag", d, 8'h10);
    cmp_pulse(16'h0050);
    rd(2'd0, d); chk("R4 match sets flag", d, 8'h90);
    wr(2'd0, 8'h10);
    cmp_pulse(16'h0051);
    rd(2'd0, d); chk("R4 near miss leaves flag clear", d, 8'h10);
  endtask

  task automatic t_interlock;
    logic [7:0] d;
    wr(2'd0, 8'h50);
    cmp_pulse(16'h0050);
    chk("R9 irq raised", irq_req, 1);
    chk("R9 dma quiet", dma_req, 0);
    wr(2'd0, 8'h50);
    chk("R5 zero write without read keeps flag", irq_req, 1);
    rd(2'd0, d); chk("R5 flag visible", d, 8'hD0);
    wr(2'd0, 8'h50);
    chk("R5 armed zero write clears", irq_req, 0);
  endtask

  task automatic t_late_event;
    logic [7:0] d;
    cmp_pulse(16'h0050);
    rd(2'd0, d);
    cmp_pulse(16'h0050);
    wr(2'd0, 8'h50);
    chk("R6 event between read and write keeps flag", irq_req, 1);
    rd(2'd0, d);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h50; bus_wr = 1'b1; cnt_value = 16'h0050;
    @(negedge clk);
    bus_wr = 1'b0; cnt_value = IDLE_CNT;
    #1 chk("R6 event in write cycle keeps flag", irq_req, 1);
    clear_flag(8'h50);
    chk("R6 normal clear afterwards", irq_req, 0);
  endtask

  task automatic t_write_one;
    logic [7:0] d;
    cmp_pulse(16'h0050);
    rd(2'd0, d);
    wr(2'd0, 8'hD0);
    rd(2'd0, d); chk("R7 one write leaves flag", d, 8'hD0);
    wr(2'd0, 8'h50);
    rd(2'd0, d); chk("R7 later zero write clears", d, 8'h50);
  endtask

  task automatic t_dma;
    logic [7:0] d;
    svc_dma = 1'b1;
    cmp_pulse(16'h0050);
    chk("R9 dma raised", dma_req, 1);
    chk("R9 irq quiet in dma mode", irq_req, 0);
    rd(2'd0, d);
    wr(2'd0, 8'h50);
    chk("R8 status zero write ignored in dma mode", dma_req, 1);
    rd(2'd2, d);
    chk("R8 low read clears", dma_req, 0);
    cmp_pulse(16'h0050);
    chk("R8 flag set again", dma_req, 1);
    wr(2'd2, 8'h50);
    chk("R8 low write clears", dma_req, 0);
    svc_dma = 1'b0;
    wr(2'd0, 8'h10);
    cmp_pulse(16'h0050);
    chk("R9 enable off: irq quiet", irq_req, 0);
    chk("R9 enable off: dma quiet", dma_req, 0);
    rd(2'd0, d); chk("R9 flag set with enable off", d, 8'h90);
    wr(2'd0, 8'h10);
  endtask

  task automatic t_block;
    logic [7:0] d;
    logic [15:0] v;
    cap_pin = 1'b0;
    wr(2'd0, 8'h44);
    cnt_value = 16'h1234;
    set_pin(1'b1);
    clear_flag(8'h44);
    chk("R10 start clear", irq_req, 0);
    rd(2'd1, d); chk("R11 high byte", d, 8'h12);
    cnt_value = 16'hABCD;
    set_pin(1'b0);
    set_pin(1'b1);
    chk("R10 event held while blocked", irq_req, 0);
    rd(2'd0, d); chk("R10 status flag clear while blocked", d, 8'h44);
    rd(2'd2, d); chk("R11 low byte frozen at high read", d, 8'h34);
    rd(2'd0, d); chk("R10 pending event sets flag on low read", d, 8'hC4);
    rd_val(v); chk("R3 capture during block stored", v, 16'hABCD);
    wr(2'd0, 8'h44);
    chk("R10 cleanup clear", irq_req, 0);
    cnt_value = IDLE_CNT;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_capture();
    t_compare();
    t_interlock();
    t_late_event();
    t_write_one();
    t_dma();
    t_block();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule